// File: doc/BRIEF.md
# Calendar Time Counter with Update Cycle

The block keeps wall-clock time and date in eight registers: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A prescaler counts pulses of a 32.768 kHz reference, and each time it completes a second the time registers advance by one second, with carries through to the century. Before each update a flag marks the update-in-progress window. After each update a sticky flag in a status register records that an update has ended.

Software reaches the block through a simple register port: one index shared by reads and writes, write data with a write strobe, combinational read data, and a read strobe that clears the status flag when it hits the status index. Two control registers set the behaviour. The first holds a divider-select field, which can hold the prescaler in reset. The second holds a freeze bit and the data-format bits. Time is kept internally in binary and converted at the register port, so values can be read and written as packed BCD or as binary, and the hour as 24-hour or as 12-hour with a PM bit.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read as follows. Index 0 seconds = 0x00. Index 1 minutes = 0x00. Index 2 hours = 0x00. Index 3 day of week = 0x01. Index 4 day of month = 0x01. Index 5 month = 0x01. Index 6 year = 0x00. Index 7 century = 0x20. Index 8 control A = 0x26. Index 9 control B = 0x02. Index 10 status = 0x00. `uip_o` is 0.
- R2: Time advances only while the freeze bit (control B bit 7) is 0 and the divider field (control A bits 6:4) is 2 or less. With the divider field at 3, 4 or 5 the prescaler still runs and sets the status flag, but the time registers do not change.
- R3: With the divider field at 6 or 7, the prescaler is held at zero. No update happens, the status flag is not set, and `uip_o` is 0.
- R4: When a write to control A moves the divider field from 6 or 7 to 2 or less, the first update comes TICKS_PER_SEC/2 ticks later. Each later update comes TICKS_PER_SEC ticks after the previous one.
- R5: While time is counting, `uip_o` (also control A bit 7) is 1 for the last UIP_TICKS ticks before each update and 0 at all other times. It is 0 while the freeze bit is set.
- R6: Control A bit 7 is read-only. A write to control A stores bits 6:0 and leaves the update-in-progress indication unchanged.
- R7: Control B bit 2 = 1 selects binary encoding. When it is 0, values are packed BCD with the tens digit in bits 7:4. Conversion uses the mode in force at the time of the access.
- R8: Control B bit 1 = 1 selects 24-hour hours (0 to 23). When it is 0, the hour reads and writes as 1 to 12 with bit 7 set for PM, and both midnight and noon are encoded as 12.
- R9: Each update carries through the fields in this order: seconds 0–59, minutes 0–59, hours 0–23, day of week 1–7, then day of month, then month 1–12, then year 0–99, then century. The month lengths are 31, 28 or 29, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31. February has 29 days when the year is divisible by 4.
- R10: Every update (with the divider not held) sets status bit 4. A read-strobe at index 10 clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: While frozen, writes to the time registers are stored unchanged. When the freeze bit is cleared, counting resumes from the stored values.
- R12: If a time-register write coincides with an update, the written field takes the written value. All other fields advance from the values they held before the write, including carries out of the written field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per period of the 32.768 kHz reference |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Read strobe; clears the status flag at index 10 |
| addr_i | input | 4 | Register index for reads and writes |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` |
| uip_o | output | 1 | Update-in-progress indication |
| uf_o | output | 1 | Update-ended status flag |

## Verification
Two events can fall on the same clock edge. One is a software write to a time register, and the other is the once-per-second update. The bench places a seconds write on the exact edge where the prescaler wraps, with seconds at 59. It expects the written seconds value to win while the minute still takes the carry from the old 59. In the same way, a status-clearing read is placed on an update edge, and the flag must remain set. Calendar rollover is swept over every month end of a leap year and a non-leap year and over the century boundary. Hour encoding is swept over all 24 hours in both data formats.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [3:0] IDX_SEC    = 4'd0;
  localparam logic [3:0] IDX_MIN    = 4'd1;
  localparam logic [3:0] IDX_HOUR   = 4'd2;
  localparam logic [3:0] IDX_WDAY   = 4'd3;
  localparam logic [3:0] IDX_MDAY   = 4'd4;
  localparam logic [3:0] IDX_MONTH  = 4'd5;
  localparam logic [3:0] IDX_YEAR   = 4'd6;
  localparam logic [3:0] IDX_CENT   = 4'd7;
  localparam logic [3:0] IDX_CTRL_A = 4'd8;
  localparam logic [3:0] IDX_CTRL_B = 4'd9;
  localparam logic [3:0] IDX_STAT   = 4'd10;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] minute;
    logic [6:0] hour;
    logic [6:0] wday;
    logic [6:0] mday;
    logic [6:0] month;
    logic [6:0] year;
    logic [6:0] cent;
  } rtc_time_t;

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [6:0] t, u;
    t = v / 7'd10;
    u = v % 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    logic [7:0] r;
    r = 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    return r[6:0];
  endfunction

  function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UIP_TICKS     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  input  logic release_i,
  input  logic count_en_i,
  output logic step_o,
  output logic uip_o
);
  localparam int unsigned PW = $clog2(TICKS_PER_SEC);
  localparam logic [PW-1:0] LAST     = PW'(TICKS_PER_SEC - 1);
  localparam logic [PW-1:0] HALF     = PW'(TICKS_PER_SEC / 2);
  localparam logic [PW-1:0] UIP_FROM = PW'(TICKS_PER_SEC - UIP_TICKS);

  logic [PW-1:0] presc_q;

  assign step_o = tick_i && !hold_i && (presc_q == LAST);
  assign uip_o  = count_en_i && (presc_q >= UIP_FROM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          presc_q <= '0;
    else if (release_i)   presc_q <= HALF;     // first update half a second out
    else if (hold_i)      presc_q <= '0;
    else if (tick_i)      presc_q <= (presc_q == LAST) ? '0 : presc_q + 1'b1;
  end

  AST_UIP_DROPS_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !uip_o); // R5
endmodule

// File: rtl/rtc_codec.sv
module rtc_codec
  import rtc_pkg::*;
(
  input  logic       binary_i,
  input  logic       h24_i,
  input  logic [2:0] sel_i,
  input  logic [7:0] wr_data_i,
  input  rtc_time_t  time_i,
  output logic [6:0] wr_val_o,
  output logic [7:0] rd_val_o
);
  logic       is_hour12;
  logic [6:0] fld, h12, raw;

  assign is_hour12 = (sel_i == IDX_HOUR[2:0]) && !h24_i;

  always_comb begin
    case (sel_i)
      3'd0:    fld = time_i.sec;
      3'd1:    fld = time_i.minute;
      3'd2:    fld = time_i.hour;
      3'd3:    fld = time_i.wday;
      3'd4:    fld = time_i.mday;
      3'd5:    fld = time_i.month;
      3'd6:    fld = time_i.year;
      default: fld = time_i.cent;
    endcase
    h12 = fld % 7'd12;
    if (h12 == 7'd0) h12 = 7'd12;
    if (is_hour12)
      rd_val_o = (binary_i ? {1'b0, h12} : bin_to_bcd(h12)) | {(fld >= 7'd12), 7'b0};
    else
      rd_val_o = binary_i ? {1'b0, fld} : bin_to_bcd(fld);
  end

  always_comb begin
    if (is_hour12) begin
      raw      = binary_i ? wr_data_i[6:0] : bcd_to_bin({1'b0, wr_data_i[6:0]});
      wr_val_o = (raw % 7'd12) + (wr_data_i[7] ? 7'd12 : 7'd0);
    end else begin
      raw      = '0;
      wr_val_o = binary_i ? wr_data_i[6:0] : bcd_to_bin(wr_data_i);
    end
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
#(
  parameter int unsigned RST_CENTURY = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       run_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [6:0] wr_val_i,
  output rtc_time_t  time_o
);
  localparam rtc_time_t RST_TIME = '{sec: 7'd0, minute: 7'd0, hour: 7'd0, wday: 7'd1,
                                     mday: 7'd1, month: 7'd1, year: 7'd0,
                                     cent: 7'(RST_CENTURY)};
  rtc_time_t cur_q, nxt;

  assign time_o = cur_q;

  always_comb begin
    nxt = cur_q;
    if (step_i && run_i) begin
      if (cur_q.sec >= 7'd59) begin
        nxt.sec = 7'd0;
        if (cur_q.minute >= 7'd59) begin
          nxt.minute = 7'd0;
          if (cur_q.hour >= 7'd23) begin
            nxt.hour = 7'd0;
            nxt.wday = (cur_q.wday >= 7'd7) ? 7'd1 : cur_q.wday + 7'd1;
            if (cur_q.mday >= month_days(cur_q.month, cur_q.year)) begin
              nxt.mday = 7'd1;
              if (cur_q.month >= 7'd12) begin
                nxt.month = 7'd1;
                if (cur_q.year >= 7'd99) begin
                  nxt.year = 7'd0;
                  nxt.cent = (cur_q.cent >= 7'd99) ? 7'd0 : cur_q.cent + 7'd1;
                end else nxt.year = cur_q.year + 7'd1;
              end else nxt.month = cur_q.month + 7'd1;
            end else nxt.mday = cur_q.mday + 7'd1;
          end else nxt.hour = cur_q.hour + 7'd1;
        end else nxt.minute = cur_q.minute + 7'd1;
      end else nxt.sec = cur_q.sec + 7'd1;
    end
    // written field overrides; carries above came from the old value
    if (wr_en_i) begin
      case (wr_sel_i)
        3'd0:    nxt.sec    = wr_val_i;
        3'd1:    nxt.minute = wr_val_i;
        3'd2:    nxt.hour   = wr_val_i;
        3'd3:    nxt.wday   = wr_val_i;
        3'd4:    nxt.mday   = wr_val_i;
        3'd5:    nxt.month  = wr_val_i;
        3'd6:    nxt.year   = wr_val_i;
        default: nxt.cent   = wr_val_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= RST_TIME;
    else         cur_q <= nxt;
  end

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && run_i && !wr_en_i && cur_q.sec == 7'd59) |=> (cur_q.sec == 7'd0)); // R9
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UIP_TICKS     = 8,
  parameter int unsigned RST_CENTURY   = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       uip_o,
  output logic       uf_o
);
  logic [6:0] ctrl_a_q;
  logic [7:0] ctrl_b_q;
  logic       uf_q;
  logic       div_hold, div_ok, frozen, run, release_div, step;
  logic       wr_a, wr_b, wr_time, clr_uf;
  logic [6:0] wr_val;
  logic [7:0] time_rd;
  rtc_time_t  time_q;

  assign div_hold    = (ctrl_a_q[6:5] == 2'b11);
  assign div_ok      = (ctrl_a_q[6:4] <= 3'd2);
  assign frozen      = ctrl_b_q[7];
  assign run         = div_ok && !frozen;
  assign wr_a        = wr_en_i && (addr_i == IDX_CTRL_A);
  assign wr_b        = wr_en_i && (addr_i == IDX_CTRL_B);
  assign wr_time     = wr_en_i && !addr_i[3];
  assign clr_uf      = rd_en_i && (addr_i == IDX_STAT);
  assign release_div = wr_a && div_hold && (wr_data_i[6:4] <= 3'd2);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) presc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .hold_i(div_hold),
    .release_i(release_div), .count_en_i(run), .step_o(step), .uip_o(uip_o)
  );

  rtc_codec codec_i (
    .binary_i(ctrl_b_q[2]), .h24_i(ctrl_b_q[1]), .sel_i(addr_i[2:0]),
    .wr_data_i(wr_data_i), .time_i(time_q), .wr_val_o(wr_val), .rd_val_o(time_rd)
  );

  rtc_time_chain #(.RST_CENTURY(RST_CENTURY)) chain_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .run_i(run), .wr_en_i(wr_time),
    .wr_sel_i(addr_i[2:0]), .wr_val_i(wr_val), .time_o(time_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_a_q <= 7'h26;
      ctrl_b_q <= 8'h02;
      uf_q     <= 1'b0;
    end else begin
      if (wr_a) ctrl_a_q <= wr_data_i[6:0];
      if (wr_b) ctrl_b_q <= wr_data_i;
      if (step)        uf_q <= 1'b1;   // set beats clear
      else if (clr_uf) uf_q <= 1'b0;
    end
  end

  assign uf_o = uf_q;

  always_comb begin
    if (!addr_i[3]) rd_data_o = time_rd;
    else begin
      case (addr_i)
        IDX_CTRL_A: rd_data_o = {uip_o, ctrl_a_q};
        IDX_CTRL_B: rd_data_o = ctrl_b_q;
        IDX_STAT:   rd_data_o = {3'b000, uf_q, 4'b0000};
        default:    rd_data_o = 8'h00;
      endcase
    end
  end

  AST_UIP_LEADS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && run) |-> uip_o); // R5
  AST_HOLD_NO_UF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_hold && !uf_q) |=> !uf_q); // R3
  AST_UF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_q && !clr_uf) |=> uf_q); // R10
  AST_SET_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen && !wr_time) |=> $stable(time_q)); // R2
endmodule

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 32;
  localparam int UIPT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       uip, uf;
  int         checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .uip_o(uip), .uf_o(uf)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_clr(output logic [7:0] d);
    @(negedge clk); addr = 4'd10; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic read_all(output logic [63:0] v);
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), b);
      v = {v[55:0], b};
    end
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(4'd8, 8'h60);
    for (int i = 0; i < 8; i++) wr(4'(i), t[63-8*i -: 8]);
    wr(4'd8, 8'h20);   // release: first update after TPS/2 ticks
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [63:0] v;
    logic        bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_all(v);
    check_eq("R1 time", v, 64'h00_00_00_01_01_01_00_20);
    rd(4'd8, b);  check_eq("R1 ctrl A", b, 8'h26);
    rd(4'd9, b);  check_eq("R1 ctrl B", b, 8'h02);
    rd(4'd10, b); check_eq("R1 status", b, 8'h00);
    check_eq("R1 uip", uip, 1'b0);

    // R4 R5 R6 R12: release phase, UIP window, write on the update edge
    set_time(64'h59_10_12_03_15_06_24_20);
    ticks(TPS/2 - UIPT - 1);
    check_eq("R5 uip low before window", uip, 1'b0);
    ticks(1);
    check_eq("R5 uip high in window", uip, 1'b1);
    rd(4'd8, b); check_eq("R6 ctrl A shows uip", b, 8'hA0);
    wr(4'd8, 8'h2A);
    rd(4'd8, b); check_eq("R6 write keeps uip", b, 8'hAA);
    ticks(UIPT - 1);
    rd(4'd0, b); check_eq("R4 no update before half second", b, 8'h59);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 4'd0; wdata = 8'h30;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    read_all(v);
    check_eq("R12 write wins, carry kept", v[63:40], 24'h30_11_12);
    check_eq("R10 uf after update", uf, 1'b1);
    check_eq("R5 uip low after update", uip, 1'b0);

    // R10 clear, and set beating clear
    rd_clr(b); check_eq("R10 status read", b, 8'h10);
    rd_clr(b); check_eq("R10 status cleared", b, 8'h00);
    ticks(TPS - 1);
    @(negedge clk); tick = 1'b1; rd_en = 1'b1; addr = 4'd10;
    @(negedge clk); tick = 1'b0; rd_en = 1'b0;
    rd(4'd10, b); check_eq("R10 set wins over clear", b, 8'h10);
    rd(4'd0, b);  check_eq("R4 full-second cadence", b, 8'h31);
    rd_clr(b);
    rd(4'd10, b); check_eq("R10 cleared again", b, 8'h00);

    // R3 divider hold
    wr(4'd8, 8'h60);
    bad = 1'b0;
    for (int i = 0; i < 100; i++) begin
      ticks(1);
      if (uip !== 1'b0) bad = 1'b1;
    end
    check_eq("R3 uip stays low in hold", bad, 1'b0);
    rd(4'd0, b);  check_eq("R3 time frozen in hold", b, 8'h31);
    rd(4'd10, b); check_eq("R3 no uf in hold", b, 8'h00);

    // R2 divider field 3: prescaler runs, time does not
    wr(4'd8, 8'h30);
    ticks(40);
    rd(4'd0, b);  check_eq("R2 field 3 no count", b, 8'h31);
    check_eq("R5 no uip when not counting", uip, 1'b0);
    rd_clr(b);    check_eq("R2 field 3 sets uf", b, 8'h10);

    // R2 R11 freeze bit
    wr(4'd8, 8'h60);
    wr(4'd8, 8'h20);
    wr(4'd9, 8'h82);
    bad = 1'b0;
    for (int i = 0; i < 2*TPS; i++) begin
      ticks(1);
      if (uip !== 1'b0) bad = 1'b1;
    end
    check_eq("R5 uip low while frozen", bad, 1'b0);
    rd(4'd0, b); check_eq("R2 frozen time", b, 8'h31);
    wr(4'd0, 8'h45);
    wr(4'd1, 8'h20);
    rd(4'd0, b); check_eq("R11 write stored while frozen", b, 8'h45);
    wr(4'd9, 8'h02);
    ticks(TPS/2 - 1);
    rd(4'd0, b); check_eq("R11 not yet resumed", b, 8'h45);
    ticks(1);
    read_all(v);
    check_eq("R11 resume from written", v[63:48], 16'h46_20);

    // R9 month-end sweep, leap and non-leap, BCD 24-hour
    for (int y = 23; y <= 24; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_time({8'h59, 8'h59, 8'h23, 8'h07, bcd(dim(m, y)), bcd(m), bcd(y), 8'h20});
        ticks(TPS/2);
        read_all(v);
        check_eq($sformatf("R9 month end y=%0d m=%0d", y, m), v,
                 {8'h00, 8'h00, 8'h00, 8'h01, 8'h01, bcd(m == 12 ? 1 : m + 1),
                  bcd(m == 12 ? y + 1 : y), 8'h20});
      end
    end
    set_time(64'h59_59_23_02_28_02_24_20);
    ticks(TPS/2);
    read_all(v);
    check_eq("R9 leap Feb 28", v, 64'h00_00_00_03_29_02_24_20);
    set_time(64'h59_59_23_05_31_12_99_20);
    ticks(TPS/2);
    read_all(v);
    check_eq("R9 century carry", v, 64'h00_00_00_06_01_01_00_21);
    set_time(64'h59_59_10_04_10_03_24_20);
    ticks(TPS/2);
    read_all(v);
    check_eq("R9 hour carry", v, 64'h00_00_11_04_10_03_24_20);

    // R7 R8 hour encodings for every hour
    wr(4'd9, 8'h06);
    wr(4'd8, 8'h60);
    for (int h = 0; h < 24; h++) begin
      int h12;
      h12 = (h % 12 == 0) ? 12 : h % 12;
      wr(4'd2, 8'(h));
      wr(4'd9, 8'h04);
      rd(4'd2, b);
      check_eq($sformatf("R8 binary 12h h=%0d", h), b, 8'(h12) | (h >= 12 ? 8'h80 : 8'h00));
      wr(4'd9, 8'h00);
      rd(4'd2, b);
      check_eq($sformatf("R8 bcd 12h h=%0d", h), b, bcd(h12) | (h >= 12 ? 8'h80 : 8'h00));
      wr(4'd9, 8'h02);
      rd(4'd2, b);
      check_eq($sformatf("R7 bcd 24h h=%0d", h), b, bcd(h));
      wr(4'd9, 8'h06);
    end
    wr(4'd0, 8'h2D);
    wr(4'd9, 8'h02);
    rd(4'd0, b); check_eq("R7 binary write, bcd read", b, 8'h45);
    wr(4'd9, 8'h04);
    wr(4'd2, 8'h8C);
    wr(4'd9, 8'h06);
    rd(4'd2, b); check_eq("R8 12 PM is noon", b, 8'h0C);
    wr(4'd9, 8'h04);
    wr(4'd2, 8'h0C);
    wr(4'd9, 8'h06);
    rd(4'd2, b); check_eq("R8 12 AM is midnight", b, 8'h00);

    // R8 R9 12-hour rollover in BCD
    wr(4'd9, 8'h00);
    set_time(64'h59_59_91_03_15_06_24_20);
    ticks(TPS/2);
    read_all(v);
    check_eq("R8 11 PM to 12 AM", v, 64'h00_00_12_04_16_06_24_20);
    set_time(64'h59_59_11_03_15_06_24_20);
    ticks(TPS/2);
    read_all(v);
    check_eq("R8 11 AM to 12 PM", v, 64'h00_00_92_03_15_06_24_20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule